// File: doc/BRIEF.md
# Lockable Privileged Flash Control Register Bank

This block is the register front end of a flash controller. It sits on a simple synchronous register bus and holds a 16-bit configuration word plus three protection and access-control words: a region-protection word, a privileged-access word and a data-access word. Every access is checked against the privilege level of the bus master. A user-mode access to a privileged location returns a transfer error in the same cycle and changes nothing.

The configuration word carries a lock bit that can only be set. Once it is set, it freezes the three protection and access-control words until reset. The same word holds five interrupt enables. Each enable is paired with one status flag that enters from the rest of the controller. The enabled flags are ORed into one registered interrupt request. A user-readable status location reports the raw flags. All other offsets in the window read as zero and ignore writes.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the configuration, protection, privileged-access and data-access words all read 0, and `irq` is 0.
- R2: The configuration word sits at offset 0x00. Bits 15:11 always read 0 and ignore writes. Bits 9:5 (interrupt enables) and bits 4:0 (key field) take the written value on a privileged write.
- R3: Bit 10 of the configuration word is the lock. A privileged write with bit 10 = 1 sets it. A later write with bit 10 = 0 leaves it at 1 until reset.
- R4: The protection word at 0x10, the privileged-access word at 0x14 and the data-access word at 0x18 are 32 bits wide. Each takes a privileged write while the lock is 0 and ignores every write while the lock is 1.
- R5: Every offset except 0x20 is privileged. A user-mode (`bus_sup` = 0) read or write there raises `bus_err`, returns read data 0 and changes no register.
- R6: Offset 0x20 is the status location, open to both modes. It reads `flag_in` in bits 4:0 and zero above, never raises `bus_err`, and ignores writes.
- R7: A privileged access to any other offset (0x04, 0x08, 0x0C, 0x1C, 0x24, any unaligned or higher offset) reads 0, raises no error and has no effect.
- R8: `irq` is a register loaded each cycle with the OR over i of `flag_in[i]` AND its enable. The enables are config bit 9 for `flag_in[4]` (protection violation), bit 8 for `flag_in[3]` (access error), and bits 7:5 for `flag_in[2:0]`. The request therefore follows its inputs one cycle later.
- R9: `bus_err` is high only in a cycle where `bus_wr` or `bus_rd` is high, and it is combinational with that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte offset within the register window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_sup | input | 1 | 1 = privileged master, 0 = user master |
| bus_rdata | output | DATA_W (32) | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Transfer-error response, same cycle as the strobe |
| flag_in | input | 5 | Status flags; bit 4 protection violation, bit 3 access error |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a master never raises `bus_wr` and `bus_rd` in the same cycle, and the block checks this assumption itself. The bench drives one strobe per cycle, changes strobes and flags only on the falling edge, and holds `flag_in` steady across every register sweep. It sweeps every one of the 64 offsets in both privilege modes, before and after the lock is set. It also sweeps all 1024 combinations of enable and flag.

// File: rtl/fcr_pkg.sv
// Package: shared offsets, selector type and configuration-word layout
// for the flash control register bank. Assumes byte offsets, word aligned.
package fcr_pkg;
    localparam int CFG_W    = 16;
    localparam int NSRC     = 5;
    localparam int LOCK_BIT = 10;
    localparam int IEN_LSB  = 5;
    localparam int KEY_W    = 5;

    localparam int OFF_CFG  = 'h00;
    localparam int OFF_PROT = 'h10;
    localparam int OFF_SACC = 'h14;
    localparam int OFF_DACC = 'h18;
    localparam int OFF_STAT = 'h20;

    localparam int NLK = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_PROT,
        SEL_SACC,
        SEL_DACC,
        SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/fcr_decode.sv
// Address decoder and privilege check. It maps the offset to a register
// selector, raises the transfer error for user accesses to privileged
// offsets and produces the per-register write enables.
// Assumes at most one of wr_i / rd_i is high in any cycle.
module fcr_decode
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              sup_i,
    output reg_sel_e          sel_o,
    output logic              err_o,
    output logic              rd_ok_o,
    output logic              wr_cfg_o,
    output logic [NLK-1:0]    wr_lk_o
);
    logic strobe;
    logic allowed;

    // Map the offset to a register selector.
    always_comb begin
        case (addr_i)
            ADDR_W'(OFF_CFG):  sel_o = SEL_CFG;
            ADDR_W'(OFF_PROT): sel_o = SEL_PROT;
            ADDR_W'(OFF_SACC): sel_o = SEL_SACC;
            ADDR_W'(OFF_DACC): sel_o = SEL_DACC;
            ADDR_W'(OFF_STAT): sel_o = SEL_STAT;
            default:           sel_o = SEL_NONE;
        endcase
    end

    // Privilege check: only the status location is open to user mode.
    always_comb begin
        strobe  = wr_i | rd_i;
        allowed = sup_i | (sel_o == SEL_STAT);
        err_o   = strobe & ~allowed;
        rd_ok_o = rd_i & allowed;
    end

    // Per-register write enables, gated by privilege.
    always_comb begin
        wr_cfg_o   = wr_i & allowed & (sel_o == SEL_CFG);
        wr_lk_o[0] = wr_i & allowed & (sel_o == SEL_PROT);
        wr_lk_o[1] = wr_i & allowed & (sel_o == SEL_SACC);
        wr_lk_o[2] = wr_i & allowed & (sel_o == SEL_DACC);
    end

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && rd_i));
    p_err_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (wr_i || rd_i));
    p_status_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_W'(OFF_STAT)) |-> !err_o);
    p_user_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sup_i) |-> (!wr_cfg_o && wr_lk_o == '0));
endmodule

// File: rtl/fcr_cfg_reg.sv
// Configuration word: sticky lock bit, interrupt enables and key field.
// Bits above the lock are not stored and read as zero.
// Assumes we_i is already qualified by privilege and address.
module fcr_cfg_reg
    import fcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [LOCK_BIT:0]  wdata_i,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               lock_o,
    output logic [NSRC-1:0]    ien_o
);
    logic            lock_q;
    logic [NSRC-1:0] ien_q;
    logic [KEY_W-1:0] key_q;

    // Lock can only be set; it clears on reset alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (we_i && wdata_i[LOCK_BIT])
            lock_q <= 1'b1;
    end

    // Enables and key field load on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            key_q <= '0;
        end else if (we_i) begin
            ien_q <= wdata_i[IEN_LSB +: NSRC];
            key_q <= wdata_i[KEY_W-1:0];
        end
    end

    // Assemble the visible word with the reserved bits tied low.
    always_comb begin
        cfg_o = {{(CFG_W-LOCK_BIT-1){1'b0}}, lock_q, ien_q, key_q};
        lock_o = lock_q;
        ien_o  = ien_q;
    end

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(ien_q) && $stable(key_q)));
endmodule

// File: rtl/fcr_lock_reg.sv
// One lockable data word. It accepts writes only while the lock input is low.
// Assumes we_i is already qualified by privilege and address.
module fcr_lock_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic         lock_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Store the write data unless the lock is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we_i && !lock_i)
            q <= wdata_i;
    end

    // Drive the stored word out.
    always_comb q_o = q;

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(q));
    p_no_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q));
endmodule

// File: rtl/fcr_irq.sv
// Interrupt combiner: ORs each flag masked by its enable into one
// registered request. Assumes the flags are synchronous to clk.
module fcr_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ien_i,
    input  logic [N-1:0] flag_i,
    output logic         irq_o
);
    logic irq_q;

    // Register the masked OR of all sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(ien_i & flag_i);
    end

    // Drive the request out.
    always_comb irq_o = irq_q;

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ien_i & flag_i)) |=> irq_q);
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(ien_i & flag_i)) |=> !irq_q);
endmodule

// File: rtl/flash_ctl_regs.sv
// Top of the flash control register bank: decoder, configuration word,
// three lockable words, interrupt combiner and read multiplexer.
// Assumes one bus strobe per cycle; read data and error are combinational.
module flash_ctl_regs
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_sup,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [NSRC-1:0]   flag_in,
    output logic              irq
);
    reg_sel_e                     sel;
    logic                         rd_ok;
    logic                         wr_cfg;
    logic [NLK-1:0]               wr_lk;
    logic [CFG_W-1:0]             cfg_q;
    logic                         lock;
    logic [NSRC-1:0]              ien;
    logic [NLK-1:0][DATA_W-1:0]   lk_q;

    fcr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .sup_i    (bus_sup),
        .sel_o    (sel),
        .err_o    (bus_err),
        .rd_ok_o  (rd_ok),
        .wr_cfg_o (wr_cfg),
        .wr_lk_o  (wr_lk)
    );

    fcr_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_cfg),
        .wdata_i (bus_wdata[LOCK_BIT:0]),
        .cfg_o   (cfg_q),
        .lock_o  (lock),
        .ien_o   (ien)
    );

    for (genvar i = 0; i < NLK; i++) begin : g_lk
        fcr_lock_reg #(.W(DATA_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (wr_lk[i]),
            .lock_i  (lock),
            .wdata_i (bus_wdata),
            .q_o     (lk_q[i])
        );
    end

    fcr_irq #(.N(NSRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_i  (ien),
        .flag_i (flag_in),
        .irq_o  (irq)
    );

    // Read multiplexer; returns zero for refused or unassigned accesses.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (sel)
                SEL_CFG:  bus_rdata = DATA_W'(cfg_q);
                SEL_PROT: bus_rdata = lk_q[0];
                SEL_SACC: bus_rdata = lk_q[1];
                SEL_DACC: bus_rdata = lk_q[2];
                SEL_STAT: bus_rdata = DATA_W'(flag_in);
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_user_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sup) |=> ($stable(cfg_q) && $stable(lk_q)));
    p_err_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));
    p_cfg_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sup && bus_addr == ADDR_W'(OFF_CFG)) |->
        (bus_rdata[CFG_W-1:LOCK_BIT+1] == '0));
endmodule

// File: tb/flash_ctl_regs_tb.sv
module flash_ctl_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_sup = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [4:0]  flag_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the visible registers.
    logic [15:0] m_cfg = '0;
    logic [31:0] m_prot = '0, m_sacc = '0, m_dacc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sup(bus_sup),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .flag_in(flag_in), .irq(irq)
    );

    function automatic bit exp_err(input int a, input bit s);
        return !s && a != 'h20;
    endfunction

    function automatic logic [31:0] exp_rd(input int a, input bit s);
        if (exp_err(a, s)) return '0;
        case (a)
            'h00: return {16'h0, m_cfg};
            'h10: return m_prot;
            'h14: return m_sacc;
            'h18: return m_dacc;
            'h20: return {27'h0, flag_in};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input int a, input bit s);
        if (exp_err(a, s)) return "R5";
        case (a)
            'h00: return "R2";
            'h10, 'h14, 'h18: return "R4";
            'h20: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] d, input bit s);
        if (exp_err(a, s)) return;
        case (a)
            'h00: m_cfg = {5'h0, m_cfg[10] | d[10], d[9:0]};
            'h10: if (!m_cfg[10]) m_prot = d;
            'h14: if (!m_cfg[10]) m_sacc = d;
            'h18: if (!m_cfg[10]) m_dacc = d;
            default: ;
        endcase
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input bit s);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_sup = s; bus_wr = 1'b1; bus_rd = 1'b0;
        #1;
        check(exp_err(a, s) ? "R5" : "R9", "write err", 32'(bus_err), 32'(exp_err(a, s)));
        model_write(a, d, s);
    endtask

    task automatic do_read(input int a, input bit s, input string req);
        @(negedge clk);
        bus_addr = 6'(a); bus_sup = s; bus_wr = 1'b0; bus_rd = 1'b1;
        #1;
        check(req, "read data", bus_rdata, exp_rd(a, s));
        check(exp_err(a, s) ? "R5" : "R9", "read err", 32'(bus_err), 32'(exp_err(a, s)));
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #1;
        check("R9", "idle err", 32'(bus_err), 32'h0);
    endtask

    task automatic readback(input string req);
        do_read('h00, 1'b1, req);
        do_read('h10, 1'b1, req);
        do_read('h14, 1'b1, req);
        do_read('h18, 1'b1, req);
        do_read('h20, 1'b1, req);
    endtask

    task automatic sweep(input logic [31:0] pat);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 64; a++) begin
                do_write(a, pat ^ 32'(a), s[0]);
                readback(tag_of(a, s[0]));
                do_read(a, s[0], tag_of(a, s[0]));
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic exp_irq, prev_irq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        #1;
        check("R1", "irq after reset", 32'(irq), 32'h0);
        readback("R1");

        flag_in = 5'h15;
        // Unlocked sweep: R4 writable words, R2 reserved bits, R5 user refusal, R7 holes
        sweep(32'h5A5A_FBFF);
        idle();

        // R3: set the lock, then try to clear it
        do_write('h00, 32'h0000_0400, 1'b1);
        do_read('h00, 1'b1, "R3");
        do_write('h00, 32'h0000_03E0, 1'b1);
        do_read('h00, 1'b1, "R3");
        check("R3", "lock bit", 32'(bus_rdata[10]), 32'h1);

        // Locked sweep: R4 words must hold
        sweep(32'h3C3C_C3C3);
        idle();

        // R8: every enable x flag combination
        for (int en = 0; en < 32; en++) begin
            flag_in = 5'h0;
            do_write('h00, 32'(en) << 5, 1'b1);
            idle();
            idle();
            prev_irq = 1'b0;
            check("R8", "irq cleared", 32'(irq), 32'h0);
            for (int fl = 0; fl < 32; fl++) begin
                @(negedge clk);
                flag_in = 5'(fl);
                exp_irq = |(5'(en) & 5'(fl));
                #1;
                check("R8", "irq before edge", 32'(irq), 32'(prev_irq));
                @(negedge clk);
                #1;
                check("R8", "irq after edge", 32'(irq), 32'(exp_irq));
                prev_irq = exp_irq;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule